// File: doc/BRIEF.md
# PMP Region Bounds Decoder

This block converts one protection entry's settings into an inclusive byte range. It takes the entry's two-bit match mode, its address register, the address register of the entry below it, and a flag that marks the lowest entry. It returns the first and last byte address of the region that the entry covers. Address registers hold byte-address bits [XLEN+1:2], so both outputs are XLEN+2 bits wide.

Four match modes are decoded. In the disabled mode the entry covers the whole space. In top-of-range mode the entry runs from the neighbour's address up to just below its own. The four-byte mode covers a single word. The naturally aligned power-of-two mode takes the region size from the number of trailing ones in the address register, which a priority encoder over the inverted register counts. Range comparison and permission checks sit downstream and are not part of this block.

The decode itself is combinational. By default a register stage follows it, so the bounds appear one clock after the inputs; a parameter removes that stage. The address width is a parameter.

Top module: `pmp_bounds_dec`

## Requirements
- R1: With mode 2'b00 (disabled), start_o is 0 and end_o is all ones.
- R2: With mode 2'b01 (top of range), start_o is prev_addr_i shifted left by 2, and end_o is addr_i shifted left by 2 minus one, taken modulo 2^(XLEN+2).
- R3: In top-of-range mode with first_i high, the neighbour address is taken as 0, so start_o is 0 whatever prev_addr_i holds.
- R4: In top-of-range mode with addr_i equal to 0, end_o wraps to all ones.
- R5: With mode 2'b10 (four-byte), start_o is addr_i shifted left by 2 and end_o is start_o plus 3.
- R6: With mode 2'b11 (power-of-two), t trailing ones in addr_i give a region of 2^(t+3) bytes whose start is addr_i with bits [t-1:0] cleared, shifted left by 2; a register whose bit 0 is 0 gives 8 bytes.
- R7: In power-of-two mode, a register whose low two bits are 01 gives a 16-byte region.
- R8: In power-of-two mode, an all-ones addr_i gives start_o 0 and end_o all ones.
- R9: In power-of-two mode, addr_i with only the top bit clear gives a 2^(XLEN+2)-byte region from 0 to all ones.
- R10: prev_addr_i and first_i have no effect on the outputs in any mode other than top of range.
- R11: With REG_OUT set, the outputs change one clock edge after the inputs, and while rst_ni is low they hold 0 (start) and all ones (end).
- R12: The decode is correct for XLEN of both 32 and 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register stage |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Match mode: 00 disabled, 01 top of range, 10 four-byte, 11 power-of-two |
| first_i | input | 1 | High for the lowest entry; forces the neighbour address to 0 |
| addr_i | input | XLEN | This entry's address register, byte bits [XLEN+1:2] |
| prev_addr_i | input | XLEN | Address register of the entry below this one |
| start_o | output | XLEN+2 | First byte address covered, inclusive |
| end_o | output | XLEN+2 | Last byte address covered, inclusive |

## Verification
The bench targets the ends of the trailing-ones count. At the all-ones register, a wrong count would give a one-bit-short or wrapped region instead of the full space. At the register with only the top bit clear, an off-by-one mask would halve the region. In between, a mask that also cleared the first zero bit would shift the base. It also checks the top-of-range case where the own address is 0, so a design that saturated instead of wrapping would show a small end address. The lowest-entry flag and the neighbour address are varied in modes that must ignore them, and a 64-bit instance covers the widest shifts, where a truncated intermediate would lose the upper bits.

// File: rtl/pmp_bnd_pkg.sv
package pmp_bnd_pkg;

    // Two-bit match mode; downstream logic decodes these exact values.
    typedef enum logic [1:0] {
        MATCH_OFF   = 2'b00,
        MATCH_TOR   = 2'b01,
        MATCH_NA4   = 2'b10,
        MATCH_NAPOT = 2'b11
    } match_mode_e;

    // Bytes covered by the smallest power-of-two region, as a shift.
    localparam int unsigned NAPOT_MIN_SHIFT = 3;

endpackage

// File: rtl/pmp_tone_cnt.sv
// Counts trailing ones of vec_i with a priority encoder over the inverted
// vector: the lowest zero bit wins. Returns W when no zero bit exists.
module pmp_tone_cnt #(
    parameter int unsigned W  = 32,
    parameter int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);

    logic [W-1:0] zero_bits;

    assign zero_bits = ~vec_i;

    always_comb begin
        cnt_o = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (zero_bits[i]) begin
                cnt_o = CW'(i);
            end
        end
    end

endmodule

// File: rtl/pmp_napot_dec.sv
// Power-of-two region decode. A count of t trailing ones covers the low
// t+3 byte-address bits; those bits are cleared for the start and set for
// the end. The all-ones case (t = XLEN) covers every bit.
module pmp_napot_dec
    import pmp_bnd_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] addr_i,
    output logic [XLEN+1:0] lo_o,
    output logic [XLEN+1:0] hi_o
);

    localparam int unsigned BW = XLEN + 2;
    localparam int unsigned CW = $clog2(XLEN + 1);

    logic [CW-1:0] ones_cnt;
    logic [BW-1:0] span_mask;
    logic [BW-1:0] byte_addr;

    pmp_tone_cnt #(
        .W  (XLEN),
        .CW (CW)
    ) u_tone_cnt (
        .vec_i (addr_i),
        .cnt_o (ones_cnt)
    );

    for (genvar g = 0; g < BW; g++) begin : g_span
        assign span_mask[g] = (int'(ones_cnt) + int'(NAPOT_MIN_SHIFT)) > g;
    end

    assign byte_addr = {addr_i, 2'b00};
    assign lo_o      = byte_addr & ~span_mask;
    assign hi_o      = byte_addr | span_mask;

endmodule

// File: rtl/pmp_lin_dec.sv
// Top-of-range and four-byte decode: plain shifts and one decrement.
module pmp_lin_dec #(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] addr_i,
    input  logic [XLEN-1:0] prev_addr_i,
    input  logic            first_i,
    output logic [XLEN+1:0] tor_lo_o,
    output logic [XLEN+1:0] tor_hi_o,
    output logic [XLEN+1:0] word_lo_o,
    output logic [XLEN+1:0] word_hi_o
);

    localparam int unsigned BW = XLEN + 2;

    logic [XLEN-1:0] below_addr;
    logic [BW-1:0]   own_byte;

    assign below_addr = first_i ? '0 : prev_addr_i;
    assign own_byte   = {addr_i, 2'b00};

    assign tor_lo_o   = {below_addr, 2'b00};
    assign tor_hi_o   = own_byte - BW'(1);
    assign word_lo_o  = own_byte;
    assign word_hi_o  = {addr_i, 2'b11};

endmodule

// File: rtl/pmp_bounds_dec.sv
module pmp_bounds_dec
    import pmp_bnd_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [1:0]      mode_i,
    input  logic            first_i,
    input  logic [XLEN-1:0] addr_i,
    input  logic [XLEN-1:0] prev_addr_i,
    output logic [XLEN+1:0] start_o,
    output logic [XLEN+1:0] end_o
);

    localparam int unsigned BW = XLEN + 2;

    typedef struct packed {
        logic [BW-1:0] lo;
        logic [BW-1:0] hi;
    } bounds_t;

    localparam bounds_t FULL_SPACE = '{lo: '0, hi: '1};

    logic [BW-1:0] tor_lo, tor_hi, word_lo, word_hi, pow_lo, pow_hi;
    bounds_t       bnd_d, bnd_q;

    pmp_lin_dec #(
        .XLEN (XLEN)
    ) u_lin (
        .addr_i      (addr_i),
        .prev_addr_i (prev_addr_i),
        .first_i     (first_i),
        .tor_lo_o    (tor_lo),
        .tor_hi_o    (tor_hi),
        .word_lo_o   (word_lo),
        .word_hi_o   (word_hi)
    );

    pmp_napot_dec #(
        .XLEN (XLEN)
    ) u_napot (
        .addr_i (addr_i),
        .lo_o   (pow_lo),
        .hi_o   (pow_hi)
    );

    always_comb begin
        bnd_d = FULL_SPACE;
        unique case (match_mode_e'(mode_i))
            MATCH_OFF:   bnd_d = FULL_SPACE;
            MATCH_TOR:   bnd_d = '{lo: tor_lo,  hi: tor_hi};
            MATCH_NA4:   bnd_d = '{lo: word_lo, hi: word_hi};
            MATCH_NAPOT: bnd_d = '{lo: pow_lo,  hi: pow_hi};
            default:     bnd_d = FULL_SPACE;
        endcase
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                bnd_q <= FULL_SPACE;
            end else begin
                bnd_q <= bnd_d;
            end
        end

        // R1: disabled entry spans the whole space on the next cycle
        assert_off_full_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mode_i == 2'b00) |=> (start_o == '0 && end_o == '1));

        // R2: top-of-range bounds are word aligned at both ends
        assert_tor_align_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mode_i == 2'b01) |=> (start_o[1:0] == 2'b00 && end_o[1:0] == 2'b11));

        // R3: lowest entry starts at zero in top-of-range mode
        assert_first_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mode_i == 2'b01 && first_i) |=> (start_o == '0));

        // R5: four-byte entry spans exactly one aligned word
        assert_word_span_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mode_i == 2'b10) |=> (end_o - start_o == BW'(3) && start_o[1:0] == 2'b00));

        // R6: power-of-two region is at least 8 bytes, a power of two, and aligned
        assert_pow_shape_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mode_i == 2'b11) |=> (end_o[2:0] == 3'b111 && start_o[2:0] == 3'b000 &&
                                   $countones(end_o - start_o + BW'(1)) <= 1 &&
                                   ((start_o & (end_o - start_o)) == '0)));

        // R8: all-ones register decodes to the full space
        assert_pow_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mode_i == 2'b11 && addr_i == '1) |=> (start_o == '0 && end_o == '1));
    end else begin : g_comb
        assign bnd_q = bnd_d;
    end

    assign start_o = bnd_q.lo;
    assign end_o   = bnd_q.hi;

endmodule

// File: tb/tb_pmp_bounds_dec.sv
`timescale 1ns/1ps
module tb_pmp_bounds_dec;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // 32-bit instance
    logic [1:0]  mode32 = 2'b00;
    logic        first32 = 1'b0;
    logic [31:0] addr32 = '0;
    logic [31:0] prev32 = '0;
    logic [33:0] lo32, hi32;

    // 64-bit instance
    logic [1:0]  mode64 = 2'b00;
    logic        first64 = 1'b0;
    logic [63:0] addr64 = '0;
    logic [63:0] prev64 = '0;
    logic [65:0] lo64, hi64;

    pmp_bounds_dec #(.XLEN(32), .REG_OUT(1'b1)) dut (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode32), .first_i(first32),
        .addr_i(addr32), .prev_addr_i(prev32), .start_o(lo32), .end_o(hi32));

    pmp_bounds_dec #(.XLEN(64), .REG_OUT(1'b1)) dut64 (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode64), .first_i(first64),
        .addr_i(addr64), .prev_addr_i(prev64), .start_o(lo64), .end_o(hi64));

    int total = 0;
    int bad   = 0;

    task automatic chk(input string req, input string what,
                       input logic [65:0] got, input logic [65:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
        end
    endtask

    typedef struct packed {
        logic [1:0]  mode;
        logic        first;
        logic [31:0] addr;
        logic [31:0] prev;
        logic [33:0] lo;
        logic [33:0] hi;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 1'b0, 32'h1234_5678, 32'h0000_0010, 34'h0_0000_0000, 34'h3_FFFF_FFFF, 8'd1},  // R1
        '{2'b01, 1'b0, 32'h0000_0400, 32'h0000_0100, 34'h0_0000_0400, 34'h0_0000_0FFF, 8'd2},  // R2
        '{2'b01, 1'b1, 32'h0000_0400, 32'h0000_0100, 34'h0_0000_0000, 34'h0_0000_0FFF, 8'd3},  // R3
        '{2'b01, 1'b0, 32'h0000_0000, 32'h0000_0000, 34'h0_0000_0000, 34'h3_FFFF_FFFF, 8'd4},  // R4
        '{2'b10, 1'b0, 32'h2000_0001, 32'h0000_0000, 34'h0_8000_0004, 34'h0_8000_0007, 8'd5},  // R5
        '{2'b11, 1'b0, 32'h0000_1000, 32'h0000_0000, 34'h0_0000_4000, 34'h0_0000_4007, 8'd6},  // R6
        '{2'b11, 1'b0, 32'h0000_1001, 32'h0000_0000, 34'h0_0000_4000, 34'h0_0000_400F, 8'd7},  // R7
        '{2'b11, 1'b0, 32'h0000_10FF, 32'h0000_0000, 34'h0_0000_4000, 34'h0_0000_47FF, 8'd6},  // R6
        '{2'b11, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 34'h0_0000_0000, 34'h3_FFFF_FFFF, 8'd8},  // R8
        '{2'b11, 1'b0, 32'h7FFF_FFFF, 32'h0000_0000, 34'h0_0000_0000, 34'h3_FFFF_FFFF, 8'd9},  // R9
        '{2'b11, 1'b0, 32'hBFFF_FFFF, 32'h0000_0000, 34'h2_0000_0000, 34'h3_FFFF_FFFF, 8'd6},  // R6
        '{2'b10, 1'b1, 32'hFFFF_FFFF, 32'h0000_1234, 34'h3_FFFF_FFFC, 34'h3_FFFF_FFFF, 8'd10}, // R10
        '{2'b11, 1'b1, 32'h0000_0003, 32'h0000_ABCD, 34'h0_0000_0000, 34'h0_0000_001F, 8'd10}, // R10
        '{2'b01, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 34'h3_FFFF_FFF8, 34'h3_FFFF_FFFB, 8'd2}   // R2
    };

    task automatic drive64(input logic [1:0] m, input logic f,
                           input logic [63:0] a, input logic [63:0] p);
        mode64 = m; first64 = f; addr64 = a; prev64 = p;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R11 watchdog got=hung exp=finished");
        summary();
        $finish;
    end

    initial begin
        // R11: reset state is the full-space bounds
        repeat (3) @(negedge clk);
        chk("R11", "reset lo32", {32'd0, lo32}, 66'd0);
        chk("R11", "reset hi32", {32'd0, hi32}, {32'd0, 34'h3_FFFF_FFFF});
        chk("R11", "reset lo64", lo64, 66'd0);
        chk("R11", "reset hi64", hi64, '1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            mode32  = VECS[i].mode;
            first32 = VECS[i].first;
            addr32  = VECS[i].addr;
            prev32  = VECS[i].prev;
            @(negedge clk);
            chk($sformatf("R%0d", VECS[i].req), $sformatf("vec%0d start", i),
                {32'd0, lo32}, {32'd0, VECS[i].lo});
            chk($sformatf("R%0d", VECS[i].req), $sformatf("vec%0d end", i),
                {32'd0, hi32}, {32'd0, VECS[i].hi});
        end

        // R11: one-edge latency; before the edge the previous bounds remain
        mode32 = 2'b10; first32 = 1'b0; addr32 = 32'h0000_0010; prev32 = '0;
        #1;
        chk("R11", "held start", {32'd0, lo32}, {32'd0, 34'h3_FFFF_FFF8});
        @(negedge clk);
        chk("R11", "new start", {32'd0, lo32}, {32'd0, 34'h0_0000_0040});

        // R12: 64-bit width
        drive64(2'b11, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
        chk("R12", "pow all-ones start", lo64, 66'd0);
        chk("R12", "pow all-ones end", hi64, '1);
        drive64(2'b11, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0);
        chk("R12", "pow top-clear start", lo64, 66'd0);
        chk("R12", "pow top-clear end", hi64, '1);
        drive64(2'b01, 1'b0, 64'h0000_0001_0000_0000, 64'h0000_0000_8000_0000);
        chk("R12", "tor start", lo64, 66'h0_0000_0002_0000_0000);
        chk("R12", "tor end", hi64, 66'h0_0000_0003_FFFF_FFFF);
        drive64(2'b11, 1'b1, 64'hFFFF_0000_0000_0001, 64'h1234);
        chk("R12", "pow 16B start", lo64, 66'h3_FFFC_0000_0000_0000);
        chk("R12", "pow 16B end", hi64, 66'h3_FFFC_0000_0000_000F);

        summary();
        $finish;
    end

endmodule